// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Window

This block takes a raster-ordered pixel stream, one pixel per accepted beat. It presents the 3x3 neighbourhood that ends at the newest pixel, with all nine pixels available in parallel, so a downstream filter can read the whole neighbourhood in one cycle. It holds the two image rows before the current one in two cascaded row stores. Each store is one image width deep. When the newer store is overwritten, it hands its old pixel to the older store. Rows further back are not kept.

Every accepted beat moves the window left by one column. The new right-hand column is taken from the older store (top), the newer store (middle) and the incoming pixel (bottom). A column index counts pixels within the row and wraps at the end of the row. A small priming state machine tracks how many full rows have arrived. A frame-start input restarts the index and the priming, so the window becomes valid again only after two complete rows and three pixels of the next row. Border policy and filter arithmetic belong to the consumer.

Top module: `line_window3`

## Requirements
- R1: While and after asynchronous reset, before any beat, `win_valid` is 0, `in_ready` is 1 and all nine window pixels read 0.
- R2: `in_ready` is low exactly in the cycles where `sof` is high. A pixel offered while `sof` is high is not accepted: it never enters the window or the row stores, and it does not count as a pixel of the new frame.
- R3: Count the accepted beats of a frame from 0, starting after the last `sof`. `win_valid` is high for exactly one cycle after each accepted beat whose count k is at least 2*IMG_W+2, and it is low in every other cycle.
- R4: After each accepted beat, window slots 6, 7 and 8 hold the pixels of beats k-2, k-1 and k. Slot i sits at `win_pix[i*PIX_W +: PIX_W]`, with i = row*3 + column, row 0 on top and column 0 on the left (oldest).
- R5: When a window is valid, slots 3, 4 and 5 hold the pixels of beats k-IMG_W-2, k-IMG_W-1 and k-IMG_W. These are the same columns one row up, taken from the newer row store, which is read before it is written.
- R6: When a window is valid, slots 0, 1 and 2 hold the pixels of beats k-2*IMG_W-2, k-2*IMG_W-1 and k-2*IMG_W. These come from the older row store, which is loaded from the newer store's old value.
- R7: In a cycle with no accepted beat, the window contents are unchanged and `win_valid` is low in the next cycle.
- R8: A `sof` pulse forces `win_valid` low in the next cycle. It restarts priming, so no pixel of an earlier frame appears in any valid window of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Frame start: clears column index and priming |
| in_valid | input | 1 | Input pixel offered |
| in_ready | output | 1 | Block can accept the offered pixel |
| in_pix | input | PIX_W | Incoming pixel |
| win_valid | output | 1 | One-cycle pulse: a full window was just formed |
| win_pix | output | 9*PIX_W | Window pixels, slot i at [i*PIX_W +: PIX_W] |

## Verification
A frame start can arrive in the same cycle as an offered pixel. In that cycle the restart of priming and the acceptance of a beat compete, and the restart must win. The bench provokes this in the middle of a partly primed frame by raising `sof` together with `in_valid`. It judges the outcome by `in_ready` going low in that cycle, `win_valid` going low after it, and the following frame producing its first valid window exactly at beat 2*IMG_W+2, with every slot matching only pixels sent after the restart. A second overlap, the column wrap falling on a row-store read-and-write, is covered by random gaps that land beats across every row boundary while full windows are compared slot by slot.

// File: rtl/win3_pkg.sv
package win3_pkg;
  typedef enum logic [1:0] {
    P_ROW0 = 2'd0,
    P_ROW1 = 2'd1,
    P_ROW2 = 2'd2,
    P_LIVE = 2'd3
  } prime_e;

  localparam int unsigned WIN_ROWS = 3;
  localparam int unsigned WIN_COLS = 3;
  localparam int unsigned STORES   = WIN_ROWS - 1;
endpackage

// File: rtl/win3_index.sv
module win3_index
  import win3_pkg::*;
#(
  parameter int unsigned IMG_W = 16,
  localparam int unsigned CW = $clog2(IMG_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic          hit
);
  localparam logic [CW-1:0] COL_LAST  = CW'(IMG_W - 1);
  localparam logic [CW-1:0] COL_THIRD = CW'(2);

  logic [CW-1:0] col_q, col_d;
  prime_e        st_q, st_d;
  logic          at_last;

  assign at_last = (col_q == COL_LAST);

  always_comb begin
    col_d = col_q;
    st_d  = st_q;
    if (clr) begin
      col_d = '0;
      st_d  = P_ROW0;
    end else if (adv) begin
      col_d = at_last ? '0 : col_q + 1'b1;
      unique case (st_q)
        P_ROW0:  if (at_last) st_d = P_ROW1;
        P_ROW1:  if (at_last) st_d = P_ROW2;
        P_ROW2:  if (col_q == COL_THIRD) st_d = P_LIVE;
        default: st_d = P_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      st_q  <= P_ROW0;
    end else begin
      col_q <= col_d;
      st_q  <= st_d;
    end
  end

  assign col = col_q;
  assign hit = adv && !clr &&
               ((st_q == P_LIVE) || ((st_q == P_ROW2) && (col_q >= COL_THIRD)));
endmodule

// File: rtl/win3_rowstore.sv
module win3_rowstore #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [0:DEPTH-1];

  // old value is visible during the write cycle; the new one lands at the edge
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/win3_shift.sv
module win3_shift
  import win3_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            adv,
  input  logic [WIN_ROWS*PIX_W-1:0]       col_in,
  output logic [WIN_ROWS*WIN_COLS*PIX_W-1:0] win
);
  for (genvar r = 0; r < WIN_ROWS; r++) begin : g_row
    logic [PIX_W-1:0] px_q [WIN_COLS];
    logic [PIX_W-1:0] px_d [WIN_COLS];

    always_comb begin
      for (int c = 0; c < WIN_COLS; c++) px_d[c] = px_q[c];
      if (adv) begin
        for (int c = 0; c < WIN_COLS - 1; c++) px_d[c] = px_q[c+1];
        px_d[WIN_COLS-1] = col_in[r*PIX_W +: PIX_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < WIN_COLS; c++) px_q[c] <= '0;
      end else begin
        for (int c = 0; c < WIN_COLS; c++) px_q[c] <= px_d[c];
      end
    end

    for (genvar c = 0; c < WIN_COLS; c++) begin : g_col
      assign win[(r*WIN_COLS + c)*PIX_W +: PIX_W] = px_q[c];
    end
  end
endmodule

// File: rtl/line_window3.sv
module line_window3
  import win3_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned IMG_W = 16,
  localparam int unsigned CW = $clog2(IMG_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PIX_W-1:0]     in_pix,
  output logic                 win_valid,
  output logic [9*PIX_W-1:0]   win_pix
);
  logic          beat;
  logic          hit;
  logic [CW-1:0] col;
  logic          win_valid_q, win_valid_d;

  // chain[0] is the live pixel, chain[s+1] is what store s returns
  logic [PIX_W-1:0] chain [STORES+1];
  logic [WIN_ROWS*PIX_W-1:0] new_col;

  assign in_ready = !sof;
  assign beat     = in_valid && in_ready;
  assign chain[0] = in_pix;

  win3_index #(.IMG_W(IMG_W)) u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sof),
    .adv   (beat),
    .col   (col),
    .hit   (hit)
  );

  for (genvar s = 0; s < STORES; s++) begin : g_store
    win3_rowstore #(.PIX_W(PIX_W), .DEPTH(IMG_W)) u_store (
      .clk   (clk),
      .we    (beat),
      .addr  (col),
      .wdata (chain[s]),
      .rdata (chain[s+1])
    );
  end

  // window row r (0 = top) is fed from chain[WIN_ROWS-1-r]
  for (genvar r = 0; r < WIN_ROWS; r++) begin : g_feed
    assign new_col[r*PIX_W +: PIX_W] = chain[WIN_ROWS-1-r];
  end

  win3_shift #(.PIX_W(PIX_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (beat),
    .col_in (new_col),
    .win    (win_pix)
  );

  always_comb begin
    win_valid_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_valid_q <= 1'b0;
    else        win_valid_q <= win_valid_d;
  end

  assign win_valid = win_valid_q;
endmodule

// File: rtl/win3_chk.sv
module win3_chk #(
  parameter int unsigned PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sof,
  input logic               in_valid,
  input logic               in_ready,
  input logic [PIX_W-1:0]   in_pix,
  input logic               win_valid,
  input logic [9*PIX_W-1:0] win_pix
);
  // R8
  sof_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !win_valid);

  // R2
  sof_beat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && in_valid) |=> $stable(win_pix));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (!win_valid && $stable(win_pix)));

  // R3
  valid_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(in_valid && in_ready));

  // R4
  newest_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (win_pix[8*PIX_W +: PIX_W] == $past(in_pix)));

  // R4
  bottom_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (win_pix[7*PIX_W +: PIX_W] == $past(win_pix[8*PIX_W +: PIX_W])));
endmodule

bind line_window3 win3_chk #(.PIX_W(PIX_W)) u_win3_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sof       (sof),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_pix    (in_pix),
  .win_valid (win_valid),
  .win_pix   (win_pix)
);

// File: tb/test_line_window3.sv
`timescale 1ns/1ps
module test_line_window3;
  localparam int PW = 8;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sof;
  logic          in_valid;
  logic          in_ready;
  logic [PW-1:0] in_pix;
  logic          win_valid;
  logic [9*PW-1:0] win_pix;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [PW-1:0] hist [0:255];
  int k = 0;
  logic [9*PW-1:0] prev_win;

  always #2.5 clk = ~clk;

  line_window3 #(.PIX_W(PW), .IMG_W(W)) i_line_window3 (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .win_valid(win_valid),
    .win_pix(win_pix)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (beat %0d)", tag, act, exp, k);
    end
  endtask

  function automatic int slot(input int i);
    return int'(win_pix[i*PW +: PW]);
  endfunction

  task automatic step(input logic v, input logic s, input logic [PW-1:0] p);
    int kk;
    bit ev;
    in_valid = v; sof = s; in_pix = p;
    #1;
    chk(in_ready == !s, "R2 in_ready", int'(in_ready), int'(!s));
    @(posedge clk);
    @(negedge clk);
    if (s) begin
      k = 0;
      chk(win_valid == 1'b0, "R8 valid after sof", int'(win_valid), 0);
      chk(win_pix == prev_win, "R2 sof beat ignored", slot(8), int'(prev_win[8*PW +: PW]));
    end else if (v) begin
      hist[k] = p;
      kk = k;
      k++;
      ev = (kk >= 2*W + 2);
      chk(win_valid == ev, "R3 win_valid", int'(win_valid), int'(ev));
      chk(slot(8) == int'(p), "R4 newest slot", slot(8), int'(p));
      if (ev) begin
        for (int r = 0; r < 3; r++) begin
          for (int c = 0; c < 3; c++) begin
            int src = kk - (2 - r) * W - (2 - c);
            string tg = (r == 2) ? "R4 bottom" : (r == 1) ? "R5 middle" : "R6 top";
            chk(slot(r*3 + c) == int'(hist[src]), tg, slot(r*3 + c), int'(hist[src]));
          end
        end
      end
    end else begin
      chk(win_valid == 1'b0, "R7 idle valid", int'(win_valid), 0);
      chk(win_pix == prev_win, "R7 idle hold", slot(8), int'(prev_win[8*PW +: PW]));
    end
    prev_win = win_pix;
  endtask

  task automatic send(input int n, input int gap_pct);
    int sent = 0;
    while (sent < n) begin
      if (($urandom % 100) < gap_pct) step(1'b0, 1'b0, PW'($urandom));
      else begin
        step(1'b1, 1'b0, PW'($urandom));
        sent++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; sof = 1'b0; in_valid = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(win_valid == 1'b0, "R1 valid", int'(win_valid), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(win_pix == '0, "R1 window", slot(8), 0);
    rst_n = 1'b1;
    @(negedge clk);
    prev_win = win_pix;

    // frame A: five rows with random gaps, crossing several row wraps
    step(1'b0, 1'b1, '0);
    send(5*W, 30);
    step(1'b0, 1'b0, '0);   // R7 directed idle
    step(1'b0, 1'b0, '0);

    // frame B: partial, then a frame start together with an offered pixel
    step(1'b0, 1'b1, '0);
    send(2*W + 8, 20);
    step(1'b1, 1'b1, 8'hAA); // R2, R8: beat dropped, priming restarts

    // frame C: back-to-back beats; first valid must be beat 2W+2 again (R8)
    send(4*W, 0);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    send(3*W + 5, 50);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule